// File: doc/BRIEF.md
# Constant-Latency Parallel Maximum Finder

The block takes a set of unsigned keys presented side by side on one wide input and reports the largest of them, the position it came from as a one-hot vector, and a one-cycle completion strobe. Every pair of keys is compared at the same moment by its own comparator. A bank of survivor flags is first set to all ones, and in the next cycle any key that loses even one of its pairings has its flag cleared. Many comparators may clear the same flag together. This causes no conflict, because every one of them writes the same value.

Only the largest key keeps its flag, and that flag steers an AND-OR selector that produces the maximum value. A run always takes three clock edges: capture, compare-and-clear, and select. This holds for any key count and any data. The cost is a comparator count that grows with the square of the key count, so the block is meant for small sets such as eight keys.

Top module: `pairwise_max_pick`

## Requirements
- R1: After reset, `done_o` is 0, `flags_o` is all zeros and `max_o` is zero.
- R2: A `start_i` seen high at a clock edge while the block is idle captures `keys_i`. Key k occupies bits [k*KEY_W +: KEY_W]. `done_o` goes high right after the third clock edge counted from and including that capturing edge, for any key values.
- R3: When `done_o` is high, `max_o` equals the largest of the captured keys, compared as unsigned numbers.
- R4: When `done_o` is high, `flags_o` has exactly one bit set. Bit k set means key k was selected.
- R5: When several keys share the largest value, the one with the lowest index is selected, and its bit is the only one set in `flags_o`.
- R6: `done_o` stays high for exactly one cycle.
- R7: `max_o` and `flags_o` keep their values from one `done_o` pulse until the next run completes.
- R8: A `start_i` that is high while a run is in progress is ignored. The keys on `keys_i` at that time do not affect the result, and the completion time of the run in progress does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a run when the block is idle |
| keys_i | input | N_KEYS*KEY_W | Keys, key k at bits [k*KEY_W +: KEY_W] |
| max_o | output | KEY_W | Largest captured key |
| flags_o | output | N_KEYS | One-hot position of the selected key |
| done_o | output | 1 | One-cycle strobe marking valid results |

## Verification
The assertions take a few things for granted. The keys are plain unsigned values. `start_i` is a clean synchronous level. The block returns to idle before a new start can take effect, so every start that arrives mid-run must be dropped rather than queued. The stimulus holds `start_i` high across a whole run with different values on `keys_i` to exercise that rule. It also combines randomly drawn key sets with directed sets built to stress the tie rule: all keys equal, and duplicated maxima at scattered and end positions. Random sets are drawn from a narrow value range about half of the time, so that ties occur often.

// File: rtl/apm_pkg.sv
package apm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMP  = 2'd1,
      ST_SEL  = 2'd2
   } apm_state_e;

   function automatic int unsigned pair_total(input int unsigned n);
      return (n * (n - 1)) / 2;
   endfunction

endpackage

// File: rtl/apm_pair_array.sv
module apm_pair_array #(
   parameter int unsigned N_KEYS = 8,
   parameter int unsigned KEY_W  = 16
) (
   input  logic [N_KEYS*KEY_W-1:0] keys_i,
   output logic [N_KEYS-1:0]       lost_o
);
   // row[a][b] set: key a loses against key b
   logic [N_KEYS-1:0] loses_to [N_KEYS];

   for (genvar a = 0; a < N_KEYS; a++) begin : g_row
      for (genvar b = 0; b < N_KEYS; b++) begin : g_col
         if (a == b) begin : g_diag
            assign loses_to[a][b] = 1'b0;
         end else if (a < b) begin : g_pair
            // the higher index loses on equal keys
            logic hi_wins;
            assign hi_wins        = keys_i[b*KEY_W +: KEY_W] > keys_i[a*KEY_W +: KEY_W];
            assign loses_to[a][b] = hi_wins;
            assign loses_to[b][a] = ~hi_wins;
         end
      end
      assign lost_o[a] = |loses_to[a];
   end

endmodule

// File: rtl/apm_flag_bank.sv
module apm_flag_bank #(
   parameter int unsigned N_KEYS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              clear_i,
   input  logic [N_KEYS-1:0] lost_i,
   output logic [N_KEYS-1:0] flags_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_o <= '0;
      end else if (init_i) begin
         flags_o <= '1;
      end else if (clear_i) begin
         flags_o <= flags_o & ~lost_i;
      end
   end

   // a flag may only fall during a clear step, never rise outside init
   AST_FLAG_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i) |=> ((flags_o & ~$past(flags_o)) == '0)); // R4

endmodule

// File: rtl/apm_onehot_sel.sv
module apm_onehot_sel #(
   parameter int unsigned N_KEYS = 8,
   parameter int unsigned KEY_W  = 16
) (
   input  logic [N_KEYS*KEY_W-1:0] keys_i,
   input  logic [N_KEYS-1:0]       sel_i,
   output logic [KEY_W-1:0]        value_o
);
   logic [KEY_W-1:0] gated [N_KEYS];

   for (genvar k = 0; k < N_KEYS; k++) begin : g_gate
      assign gated[k] = keys_i[k*KEY_W +: KEY_W] & {KEY_W{sel_i[k]}};
   end

   always_comb begin
      value_o = '0;
      for (int k = 0; k < N_KEYS; k++) begin
         value_o = value_o | gated[k];
      end
   end

endmodule

// File: rtl/pairwise_max_pick.sv
module pairwise_max_pick #(
   parameter int unsigned N_KEYS = 8,
   parameter int unsigned KEY_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [N_KEYS*KEY_W-1:0] keys_i,
   output logic [KEY_W-1:0]        max_o,
   output logic [N_KEYS-1:0]       flags_o,
   output logic                    done_o
);
   import apm_pkg::*;

   localparam int unsigned BUS_W   = N_KEYS * KEY_W;
   localparam int unsigned N_PAIRS = pair_total(N_KEYS);

   if (N_KEYS < 2) begin : g_chk_n
      $error("pairwise_max_pick: N_KEYS must be at least 2");
   end
   if (N_KEYS > 32) begin : g_chk_big
      $error("pairwise_max_pick: N_KEYS above 32 makes the pair array too large");
   end
   if (KEY_W < 1) begin : g_chk_w
      $error("pairwise_max_pick: KEY_W must be at least 1");
   end
   if (N_PAIRS < 1) begin : g_chk_p
      $error("pairwise_max_pick: no comparator pairs");
   end

   apm_state_e        state_q;
   logic [BUS_W-1:0]  key_q;
   logic [N_KEYS-1:0] lost;
   logic [N_KEYS-1:0] live_flags;
   logic [KEY_W-1:0]  pick;
   logic              accept;

   assign accept = (state_q == ST_IDLE) && start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         key_q   <= '0;
         max_o   <= '0;
         flags_o <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               key_q   <= keys_i;
               state_q <= ST_CMP;
            end
            ST_CMP:  state_q <= ST_SEL;
            ST_SEL: begin
               max_o   <= pick;
               flags_o <= live_flags;
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   apm_pair_array #(.N_KEYS(N_KEYS), .KEY_W(KEY_W)) u_pairs (
      .keys_i (key_q),
      .lost_o (lost)
   );

   apm_flag_bank #(.N_KEYS(N_KEYS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_i  (accept),
      .clear_i (state_q == ST_CMP),
      .lost_i  (lost),
      .flags_o (live_flags)
   );

   apm_onehot_sel #(.N_KEYS(N_KEYS), .KEY_W(KEY_W)) u_sel (
      .keys_i  (key_q),
      .sel_i   (live_flags),
      .value_o (pick)
   );

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !done_o ##1 !done_o ##1 done_o); // R2

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6

   AST_ONE_SURVIVOR: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($countones(flags_o) == 1)); // R4

   AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && start_i) |=> $stable(key_q)); // R8

   AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_o && state_q != ST_SEL) |=> ($stable(max_o) && $stable(flags_o))); // R7

   for (genvar k = 0; k < N_KEYS; k++) begin : g_chk_key
      AST_MAX_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
         done_o |-> (key_q[k*KEY_W +: KEY_W] <= max_o)); // R3
      AST_FLAG_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
         (done_o && flags_o[k]) |-> (key_q[k*KEY_W +: KEY_W] == max_o)); // R3
      for (genvar j = 0; j < k; j++) begin : g_lower
         AST_LOWEST_TIE: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && flags_o[k]) |-> (key_q[j*KEY_W +: KEY_W] != max_o)); // R5
      end
   end

endmodule

// File: tb/sim_pairwise_max_pick.sv
module sim_pairwise_max_pick;
   localparam int unsigned N  = 8;
   localparam int unsigned W  = 16;
   localparam time CLK_PERIOD = 10ns;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic [N*W-1:0] keys_i = '0;
   logic [W-1:0]   max_o;
   logic [N-1:0]   flags_o;
   logic           done_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   pairwise_max_pick #(.N_KEYS(N), .KEY_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .keys_i(keys_i),
      .max_o(max_o), .flags_o(flags_o), .done_o(done_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [W-1:0] exp_max(input logic [N*W-1:0] kv);
      logic [W-1:0] m = kv[W-1:0];
      for (int k = 1; k < N; k++) if (kv[k*W +: W] > m) m = kv[k*W +: W];
      return m;
   endfunction

   function automatic logic [N-1:0] exp_flags(input logic [N*W-1:0] kv);
      logic [W-1:0] m = exp_max(kv);
      for (int k = 0; k < N; k++) if (kv[k*W +: W] == m) return N'(1) << k;
      return '0;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // busy: keep start high for the whole run and drive junk keys mid-run (R8)
   task automatic run(input logic [N*W-1:0] kv, input bit busy, input string tag);
      int cnt = 0;
      @(negedge clk);
      keys_i  = kv;
      start_i = 1'b1;
      @(negedge clk);
      if (busy) keys_i = ~kv;
      else start_i = 1'b0;
      while (!done_o && cnt < 10) begin
         @(negedge clk);
         cnt++;
      end
      start_i = 1'b0;
      check(cnt == 2, busy ? "R8" : "R2", {tag, " done latency"}, cnt, 2);
      check(max_o == exp_max(kv), "R3", {tag, " max"}, max_o, exp_max(kv));
      check(flags_o == exp_flags(kv), "R4", {tag, " flags"}, flags_o, exp_flags(kv));
      @(negedge clk);
      check(!done_o, "R6", {tag, " done pulse"}, done_o, 0);
   endtask

   initial begin
      int seed_junk;
      logic [N*W-1:0] kv;
      seed_junk = $urandom(32'd7431);
      #(CLK_PERIOD * 3);
      @(negedge clk);
      check(done_o == 0 && flags_o == '0 && max_o == '0, "R1", "reset state",
            {max_o, flags_o, done_o}, 0);
      rst_n = 1'b1;

      for (int k = 0; k < N; k++) kv[k*W +: W] = W'(k + 1);
      run(kv, 0, "ascending");
      for (int k = 0; k < N; k++) kv[k*W +: W] = W'(100 - k);
      run(kv, 0, "descending");
      for (int k = 0; k < N; k++) kv[k*W +: W] = W'(50);
      kv[4*W +: W] = '1;
      run(kv, 0, "peak middle");
      for (int k = 0; k < N; k++) kv[k*W +: W] = W'(16'h1234);
      run(kv, 0, "all equal");
      check(flags_o == N'(1), "R5", "all equal picks index 0", flags_o, 1);
      for (int k = 0; k < N; k++) kv[k*W +: W] = W'(k);
      kv[2*W +: W] = W'(900);
      kv[5*W +: W] = W'(900);
      run(kv, 0, "tie 2 and 5");
      check(flags_o == N'(1) << 2, "R5", "tie lowest index", flags_o, 4);
      for (int k = 0; k < N; k++) kv[k*W +: W] = '0;
      kv[(N-1)*W +: W] = W'(1);
      run(kv, 0, "last only");
      kv = '0;
      run(kv, 0, "all zero");
      for (int k = 0; k < N; k++) kv[k*W +: W] = W'(k * 3);
      kv[6*W +: W] = W'(7777);
      run(kv, 1, "busy start");
      repeat (5) @(negedge clk);
      check(max_o == W'(7777) && flags_o == N'(1) << 6, "R7", "results held",
            {max_o, flags_o}, {W'(7777), N'(64)});

      for (int r = 0; r < 300; r++) begin
         bit narrow = ($urandom % 2) == 1;
         for (int k = 0; k < N; k++)
            kv[k*W +: W] = narrow ? W'($urandom % 4) : W'($urandom);
         run(kv, ($urandom % 8) == 0, "random");
         repeat ($urandom % 3) @(negedge clk);
      end
      finished = 1'b1;
   end

   initial begin
      for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule